// File: doc/BRIEF.md
# SPI Register Bank Target

This block is the serial target that owns a device's byte-wide register bank. A host talks to it over a four-wire SPI link in fixed 16-bit frames. Chip select goes low for each frame and high after it. The upper byte of every frame is an address byte and the lower byte is a data byte. When the top bit of the address byte is set, the frame writes the data byte into the register named by the remaining seven address bits. When that bit is clear, the frame is a read request. Bit 7 of the data byte then picks the bank: set for a control register held in the bank, clear for a 14-bit diagnostic word supplied from outside.

Reads are pipelined one frame deep. The answer to a request comes back in the frame that follows it, so a host can send requests back to back and gets the result of each frame during the next one. The link runs in SPI mode 0 with the most significant bit first, and all of it is oversampled in the system clock domain.

The rest of the device reads the stored bytes through a local port. The bank has room for the global control byte (0x00, whose bits 7:6 hold the operating mode), the two output-control bytes (0x05, 0x07), four per-channel frequency bytes (0x08 to 0x0B), four per-channel duty bytes (0x0C to 0x0F) and the watchdog byte (0x14).

Top module: `spi_regbank_target`

## Requirements
- R1: After reset every register reads 0x00 on the local port, MISO is low, and the first complete frame returns 0x0000.
- R2: A frame is exactly 16 bits sent MSB first. MOSI is sampled on the rising edge of SCK. Frame bits 15:8 are the address byte and bits 7:0 are the data byte.
- R3: A complete frame with address bit 7 = 1 loads the data byte into register address[6:0]. The new value is visible on the local port after chip select rises. The frame that follows a write returns 0x0000.
- R4: A complete frame with address bit 7 = 0 and data bit 7 = 1 is a control read. The next frame returns {8'h00, register value}, so response bits 15:8 are zero.
- R5: A complete frame with address bit 7 = 0 and data bit 7 = 0 is a diagnostic read. diag_addr carries address[6:0]. The next frame returns {2'b00, diag_data} as captured when the request frame ends. Data bits 6:0 have no effect.
- R6: Frames sent back to back each return the result of the complete frame before them.
- R7: A frame that ends with fewer or more than 16 SCK rising edges is dropped. It writes nothing, and the next complete frame returns the same response that was pending before it.
- R8: Writes to an address at or above NUM_REGS (default 32) are ignored. A control read of such an address returns 0x0000.
- R9: MISO presents response bit 15 after chip select falls and changes only after SCK falling edges, never while SCK is high. It is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select, one frame per low period |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| diag_addr_o | output | 7 | Address field of the frame being received, for the diagnostic source |
| diag_data_i | input | 14 | Diagnostic word for diag_addr_o |
| core_addr_i | input | 7 | Local read address |
| core_data_o | output | 8 | Local read data (0 for unmapped addresses) |

## Verification
The bench aims at the one-frame delay of reads. Responses are predicted from a shadow model and are compared in order, so a design that answered in the same frame, or that lost a pending answer after a write, shows up as a shifted or missing word. Frames of 12 and 18 clocks are sent with a write payload. A design that counted loosely would corrupt the mode byte or let the pending response move on. The bench also probes the top and an out-of-range address, where an index that is not checked would alias onto a low register. It samples MISO during each SCK high phase, which catches a design that shifted on the rising edge.

// File: rtl/srb_pkg.sv
package srb_pkg;
    localparam int FRAME_W = 16;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = BYTE_W - 1;
    localparam int RESP_W  = 14;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    typedef struct packed {
        logic [FRAME_W-1:0] rx;
        logic [FRAME_W-1:0] tx;
        logic [CNT_W-1:0]   cnt;
        logic               miso;
    } shf_t;

    typedef struct packed {
        logic [FRAME_W-1:0] resp;
    } top_t;
endpackage

// File: rtl/srb_sync.sv
module srb_sync #(
    parameter int         N       = 3,
    parameter int         STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o,
    output logic [N-1:0] prev_o
);
    logic [STAGES:0][N-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {(STAGES+1){RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
    assign prev_o = pipe_q[STAGES];
endmodule

// File: rtl/srb_shifter.sv
module srb_shifter
    import srb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_i,
    input  logic               sel_start_i,
    input  logic               sck_rise_i,
    input  logic               sck_fall_i,
    input  logic               mosi_i,
    input  logic [FRAME_W-1:0] load_i,
    output logic               miso_o,
    output logic [FRAME_W-1:0] word_o,
    output logic [CNT_W-1:0]   bits_o
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_start_i) begin
            st_d.tx  = load_i;
            st_d.cnt = '0;
        end else if (sel_i) begin
            if (sck_rise_i) begin
                st_d.rx = {st_q.rx[FRAME_W-2:0], mosi_i};
                if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + 1'b1;
            end
            if (sck_fall_i) st_d.tx = {st_q.tx[FRAME_W-2:0], 1'b0};
        end
        st_d.miso = sel_i ? st_d.tx[FRAME_W-1] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign miso_o = st_q.miso;
    assign word_o = st_q.rx;
    assign bits_o = st_q.cnt;

    // R2: each sampled rising edge inside a frame adds one to the bit count until saturation
    p_bit_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !sel_start_i && sck_rise_i && st_q.cnt != CNT_SAT)
        |=> (bits_o == $past(bits_o) + 1'b1));

    // R9: with the frame open and no falling SCK edge, MISO holds its value
    p_miso_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && $past(sel_i) && !sck_fall_i && !sel_start_i) |=> $stable(miso_o));
endmodule

// File: rtl/srb_regfile.sv
module srb_regfile
    import srb_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_a_addr_i,
    output logic [BYTE_W-1:0] rd_a_data_o,
    input  logic [ADDR_W-1:0] rd_b_addr_i,
    output logic [BYTE_W-1:0] rd_b_data_o
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [NUM_REGS-1:0][BYTE_W-1:0] mem_d, mem_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        assign mem_d[g] = (wr_en_i && wr_addr_i == ADDR_W'(g)) ? wr_data_i : mem_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    function automatic logic [BYTE_W-1:0] fetch(input logic [ADDR_W-1:0] a,
                                                input logic [NUM_REGS-1:0][BYTE_W-1:0] m);
        if (int'(a) < NUM_REGS) return m[a[IDX_W-1:0]];
        else                    return '0;
    endfunction

    assign rd_a_data_o = fetch(rd_a_addr_i, mem_q);
    assign rd_b_data_o = fetch(rd_b_addr_i, mem_q);

    // R3: the bank only changes on a write strobe
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(mem_q));

    // R8: a write beyond the bank leaves every register untouched
    p_oob_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && int'(wr_addr_i) >= NUM_REGS) |=> $stable(mem_q));
endmodule

// File: rtl/spi_regbank_target.sv
module spi_regbank_target
    import srb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] diag_addr_o,
    input  logic [RESP_W-1:0] diag_data_i,
    input  logic [ADDR_W-1:0] core_addr_i,
    output logic [BYTE_W-1:0] core_data_o
);
    localparam int PIN_CS   = 2;
    localparam int PIN_SCK  = 1;
    localparam int PIN_MOSI = 0;

    logic [2:0] pin_sync, pin_prev;

    srb_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_cs_n, spi_sck, spi_mosi}),
        .sync_o  (pin_sync),
        .prev_o  (pin_prev)
    );

    logic unused_pins;
    assign unused_pins = pin_prev[PIN_MOSI];

    logic sel, sel_start, sel_end, sck_rise, sck_fall;
    assign sel       = ~pin_sync[PIN_CS];
    assign sel_start = ~pin_sync[PIN_CS] &  pin_prev[PIN_CS];
    assign sel_end   =  pin_sync[PIN_CS] & ~pin_prev[PIN_CS];
    assign sck_rise  =  pin_sync[PIN_SCK] & ~pin_prev[PIN_SCK];
    assign sck_fall  = ~pin_sync[PIN_SCK] &  pin_prev[PIN_SCK];

    top_t st_d, st_q;
    logic [FRAME_W-1:0] word;
    logic [CNT_W-1:0]   bits;

    srb_shifter u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel),
        .sel_start_i (sel_start),
        .sck_rise_i  (sck_rise),
        .sck_fall_i  (sck_fall),
        .mosi_i      (pin_sync[PIN_MOSI]),
        .load_i      (st_q.resp),
        .miso_o      (spi_miso),
        .word_o      (word),
        .bits_o      (bits)
    );

    logic              frame_ok, is_wr, is_ctl;
    logic [ADDR_W-1:0] fr_addr;
    logic [BYTE_W-1:0] fr_data, ctl_data;

    assign fr_addr  = word[FRAME_W-2 -: ADDR_W];
    assign fr_data  = word[BYTE_W-1:0];
    assign is_wr    = word[FRAME_W-1];
    assign is_ctl   = fr_data[BYTE_W-1];
    assign frame_ok = sel_end && (bits == CNT_W'(FRAME_W));
    assign diag_addr_o = fr_addr;

    srb_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (frame_ok && is_wr),
        .wr_addr_i   (fr_addr),
        .wr_data_i   (fr_data),
        .rd_a_addr_i (fr_addr),
        .rd_a_data_o (ctl_data),
        .rd_b_addr_i (core_addr_i),
        .rd_b_data_o (core_data_o)
    );

    always_comb begin
        st_d = st_q;
        if (frame_ok) begin
            if (is_wr)       st_d.resp = '0;
            else if (is_ctl) st_d.resp = {{(FRAME_W-BYTE_W){1'b0}}, ctl_data};
            else             st_d.resp = {{(FRAME_W-RESP_W){1'b0}}, diag_data_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: the two top response bits never carry data
    p_resp_top_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.resp[FRAME_W-1 -: 2] == 2'b00);

    // R7: a frame closed with a wrong bit count leaves the pending response alone
    p_drop_keeps_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_end && bits != CNT_W'(FRAME_W)) |=> $stable(st_q.resp));

    // R3: a completed write queues an all-zero answer
    p_write_resp_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && is_wr) |=> (st_q.resp == '0));
endmodule

// File: tb/sim_spi_regbank_target.sv
module sim_spi_regbank_target;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic [6:0]  diag_addr;
    logic [13:0] diag_data;
    logic [6:0]  core_addr = '0;
    logic [7:0]  core_data;

    always #2.5 clk = ~clk;

    assign diag_data = {diag_addr, ~diag_addr};

    spi_regbank_target u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .diag_addr_o(diag_addr), .diag_data_i(diag_data),
        .core_addr_i(core_addr), .core_data_o(core_data)
    );

    int n_chk = 0, n_err = 0;
    bit done = 0;
    logic [15:0] exp_q[$];
    logic [15:0] got_q[$];
    string       tag_q[$];
    logic [7:0]  model[128];
    logic [15:0] pending = '0;

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [15:0] w, input int nbits, output logic [15:0] rd, output int unstable);
        logic b;
        rd = '0;
        unstable = 0;
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? w[15-i] : 1'b0;
            repeat (4) @(negedge clk);
            b = miso;
            if (i < 16) rd[15-i] = b;
            sck = 1'b1;
            repeat (4) @(negedge clk);
            if (miso !== b) unstable++;
            repeat (4) @(negedge clk);
            if (miso !== b) unstable++;
            sck = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] w, input int nbits, input string tag);
        logic [15:0] r;
        int u;
        logic [6:0] a;
        a = w[14:8];
        if (nbits == 16) begin
            exp_q.push_back(pending);
            tag_q.push_back(tag);
        end
        xfer(w, nbits, r, u);
        check(u == 0, "R9 MISO steady while SCK high", 16'(u), 16'h0);
        check(miso === 1'b0, "R9 MISO low between frames", {15'h0, miso}, 16'h0);
        if (nbits == 16) begin
            got_q.push_back(r);
            if (w[15]) begin
                if (a < 7'd32) model[a] = w[7:0];
                pending = '0;
            end else if (w[7]) begin
                pending = (a < 7'd32) ? {8'h00, model[a]} : 16'h0;
            end else begin
                pending = {2'b00, a, ~a};
            end
        end
    endtask

    task automatic core_chk(input logic [6:0] a, input logic [7:0] exp, input string req);
        core_addr = a;
        @(negedge clk);
        check(core_data === exp, req, {8'h00, core_data}, {8'h00, exp});
    endtask

    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0) begin
                logic [15:0] g, e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(g === e, t, g, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        check(miso === 1'b0, "R1 MISO low after reset", {15'h0, miso}, 16'h0);
        core_chk(7'h00, 8'h00, "R1 global control cleared");
        core_chk(7'h14, 8'h00, "R1 watchdog byte cleared");

        frame(16'h0580, 16, "R1 first frame returns zero");
        frame(16'h8040, 16, "R4 control read of 0x05 (zero)");
        core_chk(7'h00, 8'h40, "R3 mode field written");

        for (int a = 8; a < 16; a++) frame({1'b1, 7'(a), 8'(a * 7 + 3)}, 16, "R3 write answers zero");
        frame(16'h85A5, 16, "R3 write answers zero");
        frame(16'h873C, 16, "R3 write answers zero");
        frame(16'h9400, 16, "R3 write answers zero");
        frame(16'h9F7E, 16, "R3 write to top register");
        core_chk(7'h0B, 8'(11 * 7 + 3), "R3 frequency byte");
        core_chk(7'h0C, 8'(12 * 7 + 3), "R3 duty byte");
        core_chk(7'h1F, 8'h7E, "R3 top register");

        frame(16'h0080, 16, "R3 pending zero after write");
        frame(16'h0880, 16, "R6 pipelined control read 0x00");
        frame(16'h0CFF, 16, "R6 pipelined control read 0x08");
        frame(16'h0781, 16, "R6 pipelined control read 0x0C");
        frame(16'h2300, 16, "R4 control read 0x07");
        frame(16'h2345, 16, "R5 diagnostic read 0x23");
        frame(16'h7F00, 16, "R5 diagnostic ignores data bits 6:0");
        frame(16'h1F80, 16, "R5 diagnostic read 0x7F");
        frame(16'h0580, 16, "R4 control read 0x1F");

        frame(16'h80FF, 12, "R7 short frame");
        core_chk(7'h00, 8'h40, "R7 short frame wrote nothing");
        frame(16'h80FF, 18, "R7 long frame");
        core_chk(7'h00, 8'h40, "R7 long frame wrote nothing");
        frame(16'h0080, 16, "R7 pending survives dropped frames");

        frame(16'hA5C3, 16, "R6 control read 0x00");
        core_chk(7'h25, 8'h00, "R8 out-of-range write ignored");
        core_chk(7'h05, 8'hA5, "R8 no alias onto 0x05");
        frame(16'h2580, 16, "R8 write answers zero");
        frame(16'h0000, 16, "R8 out-of-range control read is zero");
        frame(16'h0080, 16, "R2 diagnostic read 0x00 result");

        repeat (8) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule